// File: doc/BRIEF.md
# Compare-Match Timer with Output Control

This block is a free-running up-counter with two compare values, A and P, that raises two sticky match flags and drives one output pin. It belongs to a timer that has been set up for compare-match output. A select input chooses which comparator resets the count to zero, so the same hardware gives either a period set by A or a period set by P. Each compare-A event can leave the pin alone, force it low, force it high or toggle it. A polarity input inverts the level that appears on the pin.

Software starts the timer by raising the run input. The cycle in which run is first seen high is spent loading the pin's start level from the initial-level select. Counting begins on the next cycle. A pause input freezes the count in place, and dropping run returns the count to zero. The flags stay set until a clear input for that flag is asserted.

Top module: `cmt_timer`

## Requirements
- R1: After reset the count is 0, both flags are 0, and the internal pin level is low, so `pin_o` equals `pol_i`.
- R2: While `run_i` is low, the count goes to 0 at the next edge and no flag is set.
- R3: The edge at which `run_i` is first sampled high does not advance the count. After that, every edge with `run_i` high and `hold_i` low adds 1, wrapping from 0x3FF to 0.
- R4: While `hold_i` is high, the count keeps its value. It resumes from that value once `hold_i` falls.
- R5: With `clr_sel_i`=1 and `cmp_a_i`≠0, an advancing edge at which the count equals `cmp_a_i` sets `flag_a_o` and returns the count to 0.
- R6: With `clr_sel_i`=1 and `cmp_a_i`=0, the counter runs the full range 0..0x3FF and wraps, and no A event occurs (no A flag, no pin action).
- R7: With `clr_sel_i`=1, `flag_p_o` is never set.
- R8: With `clr_sel_i`=0, an advancing edge at which the count equals `cmp_p_i` sets `flag_p_o` and returns the count to 0. When `cmp_p_i`=0 this happens at count 0x3FF. An A match in this mode sets `flag_a_o` but does not clear the count.
- R9: A flag stays set until its clear input is high at an edge. A match in that same edge wins, and the flag stays 1.
- R10: At the edge where `run_i` is first sampled high, the internal pin level is loaded from `init_lvl_i` (0 means low).
- R11: On each A event, `act_sel_i` acts on the internal level: 2'b00 keeps it, 2'b01 drives it low, 2'b10 drives it high, 2'b11 inverts it. No other event changes the level.
- R12: `pin_o` is the internal level XOR `pol_i`, with no register between `pol_i` and the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run enable; the rising edge restarts the pin level |
| hold_i | input | 1 | Pause; freezes the count |
| clr_sel_i | input | 1 | 1: compare A clears the count; 0: compare P clears it |
| act_sel_i | input | 2 | Pin action on an A event |
| init_lvl_i | input | 1 | Pin level loaded at start |
| pol_i | input | 1 | Inverts the pin when high |
| cmp_a_i | input | 10 | Compare value A |
| cmp_p_i | input | 10 | Compare value P |
| flag_a_clr_i | input | 1 | Clears the A flag |
| flag_p_clr_i | input | 1 | Clears the P flag |
| count_o | output | 10 | Counter value |
| flag_a_o | output | 1 | Sticky A match flag |
| flag_p_o | output | 1 | Sticky P match flag |
| pin_o | output | 1 | Output pin level |

## Verification
The count, both flags and the internal pin level are registered. Each of them changes at the first clock edge that samples the input or match causing it: a match seen while the count shows the compare value appears on the flag and on the cleared count one edge later. The pin follows a change of `pol_i` within the same cycle. The bench drives its inputs on falling edges. It compares every output against an arithmetic model one nanosecond after each rising edge, when all registers have settled. The pin-polarity path is checked one nanosecond after the input changes. Targeted checks count the exact edges after run rises, during a pause and across a full 1024-value wrap.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  localparam int FLAG_A = 0;
  localparam int FLAG_P = 1;
  localparam int NUM_FLAGS = 2;
endpackage

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic             clr_sel_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_p_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             a_evt_o,
  output logic             p_evt_o,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q;
  logic             adv, a_hit, p_hit, a_zero, wipe;

  // next-state logic
  always_comb begin
    adv     = run_i & run_q & ~hold_i;
    a_zero  = (cmp_a_i == '0);
    a_hit   = (cnt_q == cmp_a_i);
    p_hit   = (cmp_p_i == '0) ? (cnt_q == CNT_MAX) : (cnt_q == cmp_p_i);
    a_evt_o = adv & a_hit & ~(clr_sel_i & a_zero);
    p_evt_o = adv & ~clr_sel_i & p_hit;
    wipe    = (clr_sel_i & a_evt_o) | p_evt_o;
    start_o = run_i & ~run_q;
    cnt_d   = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = wipe ? '0 : (cnt_q + CNT_ONE);
    end
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_i;
    end
  end

  assign cnt_o = cnt_q;

  // R2
  stop_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));

  // R4
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && hold_i) |=> $stable(cnt_q));

  // R5
  a_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && clr_sel_i && a_evt_o) |=> (cnt_q == '0));

  // R8
  p_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && p_evt_o) |=> (cnt_q == '0));
endmodule

// File: rtl/cmt_flag.sv
module cmt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R9
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);

  // R9
  flag_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
endmodule

// File: rtl/cmt_outlvl.sv
module cmt_outlvl
  import cmt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic init_i,
  input  logic evt_i,
  input  act_e act_i,
  output logic lvl_o
);
  logic lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (start_i) begin
      lvl_d = init_i;
    end else if (evt_i) begin
      unique case (act_i)
        ACT_KEEP:   lvl_d = lvl_q;
        ACT_LOW:    lvl_d = 1'b0;
        ACT_HIGH:   lvl_d = 1'b1;
        ACT_TOGGLE: lvl_d = ~lvl_q;
        default:    lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;

  // R10
  start_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (lvl_q == $past(init_i)));

  // R11
  act_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !start_i && act_i == ACT_HIGH) |=> lvl_q);

  // R11
  act_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !start_i && act_i == ACT_TOGGLE) |=> (lvl_q != $past(lvl_q)));

  // R11
  no_evt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !start_i) |=> $stable(lvl_q));
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic             clr_sel_i,
  input  logic [1:0]       act_sel_i,
  input  logic             init_lvl_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_p_i,
  input  logic             flag_a_clr_i,
  input  logic             flag_p_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_a_o,
  output logic             flag_p_o,
  output logic             pin_o
);
  logic                 a_evt, p_evt, start, lvl;
  logic [NUM_FLAGS-1:0] flg_set, flg_clr, flg;

  cmt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .hold_i    (hold_i),
    .clr_sel_i (clr_sel_i),
    .cmp_a_i   (cmp_a_i),
    .cmp_p_i   (cmp_p_i),
    .cnt_o     (count_o),
    .a_evt_o   (a_evt),
    .p_evt_o   (p_evt),
    .start_o   (start)
  );

  assign flg_set[FLAG_A] = a_evt;
  assign flg_set[FLAG_P] = p_evt;
  assign flg_clr[FLAG_A] = flag_a_clr_i;
  assign flg_clr[FLAG_P] = flag_p_clr_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    cmt_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flg_set[g]),
      .clr_i  (flg_clr[g]),
      .flag_o (flg[g])
    );
  end

  assign flag_a_o = flg[FLAG_A];
  assign flag_p_o = flg[FLAG_P];

  cmt_outlvl u_outlvl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .init_i  (init_lvl_i),
    .evt_i   (a_evt),
    .act_i   (act_e'(act_sel_i)),
    .lvl_o   (lvl)
  );

  assign pin_o = lvl ^ pol_i;

  // R7
  no_p_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_sel_i && !flag_p_o) |=> !flag_p_o);

  // R6
  a_zero_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_sel_i && cmp_a_i == '0 && !flag_a_o) |=> !flag_a_o);
endmodule

// File: tb/cmt_timer_tb.sv
`timescale 1ns/1ps
module cmt_timer_tb_top;
  localparam int CW = 10;
  localparam logic [CW-1:0] MAXV = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          run, hold, clr_sel, init, pol, fca, fcp;
  logic [1:0]    act;
  logic [CW-1:0] ca, cp;
  logic [CW-1:0] count;
  logic          flag_a, flag_p, pin;

  int n_chk = 0;
  int n_fail = 0;

  cmt_timer #(.CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .hold_i(hold),
    .clr_sel_i(clr_sel), .act_sel_i(act), .init_lvl_i(init), .pol_i(pol),
    .cmp_a_i(ca), .cmp_p_i(cp), .flag_a_clr_i(fca), .flag_p_clr_i(fcp),
    .count_o(count), .flag_a_o(flag_a), .flag_p_o(flag_p), .pin_o(pin)
  );

  task automatic chk(string tag, int actual, int expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // arithmetic model built from the requirements
  logic [CW-1:0] m_cnt;
  logic m_runq, m_fa, m_fp, m_lvl;
  always @(posedge clk or negedge rst_n) begin : mdl
    logic adv, am, pm;
    if (!rst_n) begin
      m_cnt <= '0; m_runq <= 1'b0; m_fa <= 1'b0; m_fp <= 1'b0; m_lvl <= 1'b0;
    end else begin
      adv = run && m_runq && !hold;
      am  = adv && (m_cnt == ca) && !(clr_sel && ca == '0);
      pm  = adv && !clr_sel && ((cp == '0) ? (m_cnt == MAXV) : (m_cnt == cp));
      if (!run) m_cnt <= '0;
      else if (adv) m_cnt <= ((clr_sel && am) || pm) ? '0 : m_cnt + 1'b1;
      m_runq <= run;
      m_fa <= am ? 1'b1 : (fca ? 1'b0 : m_fa);
      m_fp <= pm ? 1'b1 : (fcp ? 1'b0 : m_fp);
      if (run && !m_runq) m_lvl <= init;
      else if (am) begin
        case (act)
          2'b01: m_lvl <= 1'b0;
          2'b10: m_lvl <= 1'b1;
          2'b11: m_lvl <= ~m_lvl;
          default: m_lvl <= m_lvl;
        endcase
      end
    end
  end

  // per-edge comparison, 1 ns after every rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      #1;
      chk("R3 count", int'(count), int'(m_cnt));
      chk("R5 flag_a", int'(flag_a), int'(m_fa));
      chk("R8 flag_p", int'(flag_p), int'(m_fp));
      chk("R11 pin", int'(pin), int'(m_lvl ^ pol));
    end
  end

  task automatic run_cfg(bit c, logic [1:0] ac, bit il, bit pl, int a, int p,
                         int ncyc, int hold_at);
    @(negedge clk); run = 0; fca = 1; fcp = 1; hold = 0;
    @(negedge clk);
    fca = 0; fcp = 0; clr_sel = c; act = ac; init = il; pol = pl;
    ca = CW'(a); cp = CW'(p); run = 1;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      hold = (i >= hold_at && i < hold_at + 3);
      fca  = (i % 11 == 10);
      fcp  = (i % 13 == 12);
    end
    hold = 0; fca = 0; fcp = 0;
  endtask

  // watchdog
  initial begin
    #(150000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int saw_wrap, fa_seen, fp_seen;
    logic [CW-1:0] prev, held;
    run = 0; hold = 0; clr_sel = 1; init = 0; pol = 1; fca = 0; fcp = 0;
    act = 2'b11; ca = CW'(3); cp = CW'(2);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 flag_a", int'(flag_a), 0);
    chk("R1 flag_p", int'(flag_p), 0);
    chk("R1 pin", int'(pin), 1);
    // R12 polarity acts without a clock edge
    pol = 0; #1;
    chk("R12 pin", int'(pin), 0);
    pol = 1; #1;
    chk("R12 pin", int'(pin), 1);

    // R3 start edge does not advance, then +1 per edge
    @(negedge clk); pol = 0; ca = CW'(20); run = 1;
    @(negedge clk); chk("R3 start", int'(count), 0);
    @(negedge clk); chk("R3 first", int'(count), 1);
    @(negedge clk); chk("R3 second", int'(count), 2);

    // R4 pause holds, resumes from held value
    hold = 1; held = count;
    repeat (5) @(negedge clk);
    chk("R4 hold", int'(count), int'(held));
    hold = 0;
    @(negedge clk); chk("R4 resume", int'(count), int'(held) + 1);

    // R2 stop clears
    run = 0;
    @(negedge clk); chk("R2 stop", int'(count), 0);
    repeat (3) @(negedge clk);
    chk("R2 stopped", int'(count), 0);

    // R10 start level, after a high-drive action
    act = 2'b10; init = 0; ca = CW'(2); run = 1;
    repeat (6) @(negedge clk);
    chk("R11 high", int'(pin), 1);
    run = 0; @(negedge clk);
    chk("R10 kept while stopped", int'(pin), 1);
    run = 1; @(negedge clk);
    chk("R10 init low", int'(pin), 0);
    run = 0; @(negedge clk);
    init = 1; act = 2'b00; run = 1; @(negedge clk);
    chk("R10 init high", int'(pin), 1);
    run = 0; @(negedge clk);

    // R9 clear input drops a set flag
    clr_sel = 0; cp = CW'(3); ca = CW'(7); run = 1;
    repeat (7) @(negedge clk);
    chk("R9 flag_p set", int'(flag_p), 1);
    fcp = 1; @(negedge clk); fcp = 0;
    if (count != CW'(0)) chk("R9 flag_p cleared", int'(flag_p), 0);
    run = 0; @(negedge clk);

    // near-exhaustive sweep of small configurations
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 6; a++)
        for (int ac = 0; ac < 4; ac++)
          for (int pl = 0; pl < 2; pl++)
            for (int il = 0; il < 2; il++)
              run_cfg(c[0], ac[1:0], il[0], pl[0], a, 4, 24, 5 + a);

    // R8 full range with compare P zero
    run_cfg(1'b0, 2'b11, 1'b0, 1'b0, 9, 0, 1030, 200);

    // R6 and R7 full range with compare A zero, clear on A
    @(negedge clk); run = 0; fca = 1; fcp = 1;
    @(negedge clk); fca = 0; fcp = 0; clr_sel = 1; ca = '0; cp = CW'(2);
    act = 2'b11; init = 0; run = 1;
    saw_wrap = 0; fa_seen = 0; fp_seen = 0; prev = '0;
    for (int i = 0; i < 1030; i++) begin
      @(negedge clk);
      if (prev == MAXV && count == '0) saw_wrap++;
      if (flag_a) fa_seen++;
      if (flag_p) fp_seen++;
      prev = count;
    end
    chk("R6 wrap", saw_wrap, 1);
    chk("R6 no A flag", fa_seen, 0);
    chk("R6 pin unchanged", int'(pin), 0);
    chk("R7 no P flag", fp_seen, 0);
    run = 0; @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule